// File: doc/BRIEF.md
# DMA Address and Command Formatter

This block turns one request for a transfer between host memory and on-card sample memory into the register traffic that starts the transfer. A request carries a byte address into sample memory, a byte count, a command byte, the number of the host DMA channel, and a flag that selects the enhanced address mode. The block works out whether the channel moves 16-bit words and converts the byte address into the word address the card expects, keeping the bank bits where the mode requires it. It packs the result into a low address word and, in enhanced mode only, a high address byte. It also builds the control byte and rounds the count that the host DMA controller receives.

Once a request is accepted, the block first clears the control register and reads it back as an acknowledge. It then writes the address registers and the control byte, one access per cycle, on a simple strobe interface, and pulses `done`. In standard mode a 16-bit channel needs 32-byte alignment. A request that breaks this rule is refused with an `err` pulse, and no register access is made. The rounded count and the channel width are held on the outputs from `done` until the next accepted request.

Top module: `smf_top`

## Requirements
- R1: The channel counts as 16-bit (`host_ch16`=1) when `req_chan` is 4 or more, and as 8-bit when it is 0 to 3.
- R2: The converted address is the byte address unchanged on an 8-bit channel. On a 16-bit channel in enhanced mode it is the byte address divided by two. On a 16-bit channel in standard mode it keeps byte-address bits 19:18 in place, shifts bits 17:0 right by one, and drops all bits above 19.
- R3: A request on a 16-bit channel in standard mode whose address bits 4:0 are not all zero gives a one-cycle `err` pulse in the cycle after acceptance, and makes no register write or read.
- R4: The low address register (select 0) receives converted-address bits 19:4. The high address register (select 1) receives {converted bits 23:20, converted bits 3:0} in `reg_wdata[7:0]`, with the upper data bits zero. The high register is written only in enhanced mode.
- R5: The control byte is `req_cmd` OR 0x01 (enable, bit 0), also OR 0x04 (16-bit channel, bit 2) when the channel is 16-bit.
- R6: `host_count` equals `req_count` rounded up to the next even value when the channel is 16-bit or command bit 6 (16-bit data) is set, and equals `req_count` otherwise. It is one bit wider than `req_count`, so 0xFFFF rounds to 0x10000.
- R7: Register accesses come one per cycle, in this order: write 0 to the control register (select 2), read the control register, write low, write high (enhanced only), write control. Exactly one of `reg_wr`, `reg_rd`, `done`, `err` is high in any cycle, or none.
- R8: `done` pulses for one cycle right after the control write. With the request driven for one cycle, `done` is seen 5 cycles after the accepting edge in standard mode and 6 cycles after it in enhanced mode.
- R9: `req_valid` is ignored while `busy` is high. The accesses and results of the running request are unchanged.
- R10: After reset, `busy`, `reg_wr`, `reg_rd`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_chan | input | 3 | Host DMA channel number |
| req_enh | input | 1 | Enhanced address mode |
| req_addr | input | ADDR_W | Byte address in sample memory |
| req_count | input | CNT_W | Transfer byte count |
| req_cmd | input | 8 | Command byte |
| busy | output | 1 | A request is in progress |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe (acknowledge) |
| reg_sel | output | 2 | Register select: 0 low, 1 high, 2 control |
| reg_wdata | output | 16 | Register write data |
| host_count | output | CNT_W+1 | Adjusted count for the host controller |
| host_ch16 | output | 1 | Channel width of the last accepted request |
| done | output | 1 | Programming finished |
| err | output | 1 | Request refused as misaligned |

## Verification
On every cycle, the assertions check that the acknowledge read follows a zero write to the control register and that `done` follows a nonzero control write. They also check that the high register is touched only in enhanced mode, that a refused request makes no access, that a forced-even count is even, and that at most one event is active at a time. The values themselves can only be shown by the bench's scenarios: the address conversion in each mode, the field packing, the control byte and the rounded count, the exact latency, and the way a request arriving while busy is ignored.

// File: rtl/smf_pkg.sv
package smf_pkg;
  localparam int CH16_MIN   = 4;
  localparam int CTRL_EN    = 0;
  localparam int CTRL_W16   = 2;
  localparam int CMD_DATA16 = 6;

  localparam logic [1:0] SEL_LOW  = 2'd0;
  localparam logic [1:0] SEL_HIGH = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CLR, PH_ACK, PH_LOW, PH_HIGH, PH_CTRL, PH_DONE, PH_ERR
  } phase_t;

  function automatic logic [31:0] f_word(logic [31:0] a, logic ch16, logic enh);
    if (!ch16) return a;
    if (enh) return a >> 1;
    return (a & 32'h000C_0000) | ((a & 32'h0003_FFFF) >> 1);
  endfunction

  function automatic logic f_bad(logic [4:0] a_lo, logic ch16, logic enh);
    return ch16 && !enh && (a_lo != 5'd0);
  endfunction

  function automatic logic [15:0] f_low(logic [31:0] w);
    return w[19:4];
  endfunction

  function automatic logic [7:0] f_high(logic [31:0] w);
    return {w[23:20], w[3:0]};
  endfunction

  function automatic logic [7:0] f_ctrl(logic [7:0] cmd, logic ch16);
    logic [7:0] c;
    c = cmd;
    c[CTRL_EN] = 1'b1;
    if (ch16) c[CTRL_W16] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/smf_calc.sv
module smf_calc import smf_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic [2:0]        chan,
  input  logic              enh,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [7:0]        cmd,
  output logic              ch16,
  output logic              bad,
  output logic              need_even,
  output logic [15:0]       low_val,
  output logic [7:0]        high_val,
  output logic [7:0]        ctrl_val,
  output logic [CNT_W:0]    cnt_val
);
  logic [31:0]    a32;
  logic [31:0]    word;
  logic [CNT_W:0] c_ext;

  assign a32       = 32'(addr);
  assign ch16      = (32'(chan) >= CH16_MIN);
  assign word      = f_word(a32, ch16, enh);
  assign bad       = f_bad(a32[4:0], ch16, enh);
  assign low_val   = f_low(word);
  assign high_val  = f_high(word);
  assign ctrl_val  = f_ctrl(cmd, ch16);
  assign need_even = ch16 || cmd[CMD_DATA16];
  assign c_ext     = {1'b0, count};
  assign cnt_val   = need_even ? c_ext + {{CNT_W{1'b0}}, c_ext[0]} : c_ext;
endmodule

// File: rtl/smf_seq.sv
module smf_seq import smf_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   bad,
  input  logic   enh_lat,
  output phase_t phase,
  output logic   accept
);
  phase_t nxt;

  assign accept = (phase == PH_IDLE) && start && !bad;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: if (start) nxt = bad ? PH_ERR : PH_CLR;
      PH_CLR:  nxt = PH_ACK;
      PH_ACK:  nxt = PH_LOW;
      PH_LOW:  nxt = enh_lat ? PH_HIGH : PH_CTRL;
      PH_HIGH: nxt = PH_CTRL;
      PH_CTRL: nxt = PH_DONE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/smf_top.sv
module smf_top import smf_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_chan,
  input  logic              req_enh,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [7:0]        req_cmd,
  output logic              busy,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [1:0]        reg_sel,
  output logic [15:0]       reg_wdata,
  output logic [CNT_W:0]    host_count,
  output logic              host_ch16,
  output logic              done,
  output logic              err
);
  logic           c_ch16, c_bad, c_even;
  logic [15:0]    c_low;
  logic [7:0]     c_high, c_ctrl;
  logic [CNT_W:0] c_cnt;
  logic           accept;
  phase_t         phase;

  logic [15:0] lat_low;
  logic [7:0]  lat_high, lat_ctrl;
  logic        lat_enh, lat_even;

  smf_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_calc (
    .chan(req_chan), .enh(req_enh), .addr(req_addr), .count(req_count),
    .cmd(req_cmd), .ch16(c_ch16), .bad(c_bad), .need_even(c_even),
    .low_val(c_low), .high_val(c_high), .ctrl_val(c_ctrl), .cnt_val(c_cnt)
  );

  smf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_valid), .bad(c_bad),
    .enh_lat(lat_enh), .phase(phase), .accept(accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_low    <= '0;
      lat_high   <= '0;
      lat_ctrl   <= '0;
      lat_enh    <= 1'b0;
      lat_even   <= 1'b0;
      host_count <= '0;
      host_ch16  <= 1'b0;
    end else if (accept) begin
      lat_low    <= c_low;
      lat_high   <= c_high;
      lat_ctrl   <= c_ctrl;
      lat_enh    <= req_enh;
      lat_even   <= c_even;
      host_count <= c_cnt;
      host_ch16  <= c_ch16;
    end
  end

  always_comb begin
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_sel   = SEL_CTRL;
    reg_wdata = 16'h0000;
    case (phase)
      PH_CLR:  reg_wr = 1'b1;
      PH_ACK:  reg_rd = 1'b1;
      PH_LOW:  begin reg_wr = 1'b1; reg_sel = SEL_LOW;  reg_wdata = lat_low; end
      PH_HIGH: begin reg_wr = 1'b1; reg_sel = SEL_HIGH; reg_wdata = {8'h00, lat_high}; end
      PH_CTRL: begin reg_wr = 1'b1; reg_wdata = {8'h00, lat_ctrl}; end
      default: ;
    endcase
  end

  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_DONE);
  assign err  = (phase == PH_ERR);
endmodule

// File: rtl/smf_chk.sv
module smf_chk #(
  parameter int CNT_W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           reg_wr,
  input logic           reg_rd,
  input logic [1:0]     reg_sel,
  input logic [15:0]    reg_wdata,
  input logic [CNT_W:0] host_count,
  input logic           done,
  input logic           err,
  input logic           lat_enh,
  input logic           lat_even
);
  assert_ack_after_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $past(reg_wr && reg_sel == 2'd2 && reg_wdata == 16'h0000));

  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd, done, err}));

  assert_high_enh_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1) |-> lat_enh);

  assert_done_after_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(reg_wr && reg_sel == 2'd2 && reg_wdata != 16'h0000));

  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!reg_wr && !reg_rd && $past(!busy)));

  assert_even_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lat_even) |-> !host_count[0]);
endmodule

bind smf_top smf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .host_count(host_count),
  .done(done), .err(err), .lat_enh(lat_enh), .lat_even(lat_even)
);

// File: tb/sim_smf_top.sv
module sim_smf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_chan = '0;
  logic        req_enh = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_count = '0;
  logic [7:0]  req_cmd = '0;
  logic        busy, reg_wr, reg_rd, host_ch16, done, err;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [16:0] host_count;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int log_n;
  logic        log_w [8];
  logic [1:0]  log_s [8];
  logic [15:0] log_d [8];
  int done_at, err_at;
  logic seen_done, seen_err;

  always #10 clk = ~clk;

  smf_top u0 (.*);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (reg_wr || reg_rd) begin
      if (log_n < 8) begin
        log_w[log_n] = reg_wr; log_s[log_n] = reg_sel; log_d[log_n] = reg_wdata;
      end
      log_n = log_n + 1;
    end
    if (done) begin seen_done = 1'b1; done_at = cyc; end
    if (err)  begin seen_err = 1'b1;  err_at = cyc;  end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned e_word(int ch, int enh, int unsigned a);
    if (ch < 4) return a;
    if (enh != 0) return a / 2;
    return ((a / 262144) % 4) * 262144 + (a % 262144) / 2;
  endfunction

  // {chan, enh, addr, count, cmd}
  localparam logic [51:0] VEC [8] = '{
    {3'd1, 1'b0, 24'h012345, 16'h0101, 8'h00},
    {3'd1, 1'b0, 24'h0ABCDE, 16'h0011, 8'h40},
    {3'd5, 1'b1, 24'h123457, 16'h0033, 8'h02},
    {3'd5, 1'b0, 24'h0C0040, 16'h0010, 8'h00},
    {3'd7, 1'b0, 24'h0C0023, 16'h0005, 8'h00},
    {3'd4, 1'b1, 24'hFFFFFF, 16'hFFFF, 8'h40},
    {3'd3, 1'b1, 24'hF00001, 16'h0007, 8'h00},
    {3'd6, 1'b0, 24'h3FFFE0, 16'h0000, 8'h80}
  };

  task automatic launch(input int ch, input int enh, input int unsigned a,
                        input int unsigned c, input int unsigned cmd, output int t0);
    @(negedge clk);
    log_n = 0; seen_done = 1'b0; seen_err = 1'b0;
    req_chan = 3'(ch); req_enh = enh[0]; req_addr = 24'(a);
    req_count = 16'(c); req_cmd = 8'(cmd); req_valid = 1'b1;
    t0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 20; k++) begin
      if (seen_done || seen_err) break;
      @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_req(input int ch, input int enh, input int unsigned a,
                           input int unsigned c, input int unsigned cmd, input int t0);
    int unsigned w, lo, hi, ct, ex_cnt;
    bit ch16, bad, even;
    int n_exp, p;
    ch16 = (ch >= 4);
    bad  = ch16 && (enh == 0) && (a % 32 != 0);
    w    = e_word(ch, enh, a);
    lo   = (w / 16) % 65536;
    hi   = ((w / 1048576) % 16) * 16 + w % 16;
    ct   = cmd | 1 | (ch16 ? 4 : 0);
    even = ch16 || ((cmd / 64) % 2 == 1);
    ex_cnt = even ? c + (c % 2) : c;
    if (bad) begin
      chk(seen_err && !seen_done, "R3 err pulse", seen_err, 1);
      chk(log_n == 0, "R3 no access", log_n, 0);
      chk(err_at == t0 + 1, "R8 err latency", err_at - t0, 1);
      return;
    end
    chk(seen_done && !seen_err, "R8 done seen", seen_done, 1);
    chk(done_at == t0 + ((enh != 0) ? 6 : 5), "R8 latency", done_at - t0, (enh != 0) ? 6 : 5);
    n_exp = (enh != 0) ? 5 : 4;
    chk(log_n == n_exp, "R7 access count", log_n, n_exp);
    if (log_n != n_exp) return;
    chk(log_w[0] && log_s[0] == 2 && log_d[0] == 0, "R7 clear ctrl", log_d[0], 0);
    chk(!log_w[1] && log_s[1] == 2, "R7 ack read", log_s[1], 2);
    chk(log_w[2] && log_s[2] == 0, "R7 low select", log_s[2], 0);
    chk(log_d[2] == 16'(lo), "R2 R4 low word", log_d[2], lo);
    p = 3;
    if (enh != 0) begin
      chk(log_w[3] && log_s[3] == 1, "R7 high select", log_s[3], 1);
      chk(log_d[3] == 16'(hi), "R4 high byte", log_d[3], hi);
      p = 4;
    end
    chk(log_w[p] && log_s[p] == 2, "R7 ctrl select", log_s[p], 2);
    chk(log_d[p] == 16'(ct), "R5 ctrl byte", log_d[p], ct);
    chk(host_count == 17'(ex_cnt), "R6 count", host_count, ex_cnt);
    chk(host_ch16 == ch16, "R1 channel width", host_ch16, ch16);
  endtask

  initial begin
    int t0;
    log_n = 0; seen_done = 0; seen_err = 0; done_at = 0; err_at = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !reg_wr && !reg_rd && !done && !err, "R10 reset outputs",
        {busy, reg_wr, reg_rd, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !reg_wr && !reg_rd && !done && !err, "R10 idle after reset",
        {busy, reg_wr, reg_rd, done, err}, 0);

    foreach (VEC[i]) begin
      launch(int'(VEC[i][51:49]), int'(VEC[i][48]), int'(VEC[i][47:24]),
             int'(VEC[i][23:8]), int'(VEC[i][7:0]), t0);
      wait_end();
      check_req(int'(VEC[i][51:49]), int'(VEC[i][48]), int'(VEC[i][47:24]),
                int'(VEC[i][23:8]), int'(VEC[i][7:0]), t0);
    end

    // R3 boundary: bit 4 set, enhanced 16-bit accepted, standard 16-bit refused
    launch(4, 1, 'h10, 3, 0, t0); wait_end(); check_req(4, 1, 'h10, 3, 0, t0);
    launch(4, 0, 'h10, 3, 0, t0); wait_end(); check_req(4, 0, 'h10, 3, 0, t0);
    // R1 boundary: channel 3 unaligned is accepted as 8-bit
    launch(3, 0, 'h11, 3, 0, t0); wait_end(); check_req(3, 0, 'h11, 3, 0, t0);

    // R9: second request while busy must be ignored
    launch(2, 0, 'h4560, 9, 0, t0);
    chk(busy == 1'b1, "R9 busy during run", busy, 1);
    req_chan = 3'd6; req_enh = 1'b1; req_addr = 24'h00ABC0;
    req_count = 16'h0021; req_cmd = 8'h40; req_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    req_valid = 1'b0;
    wait_end();
    check_req(2, 0, 'h4560, 9, 0, t0);
    chk(!busy, "R9 idle after run", busy, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule